// File: doc/BRIEF.md
# Instruction Queue Doorbell and Fetch Pointer

This block keeps the fetch side of one instruction queue. Software rings a doorbell with a number of 64-bit words. The block holds the running total of words still waiting. Each instruction is 8 words (64 bytes). While the queue is enabled and at least one whole instruction is waiting, the block raises a 64-byte fetch request at its read pointer. When the request is accepted, the block moves the pointer forward by one instruction and takes 8 words off the waiting total.

The instruction buffer is a chain of segments. Each segment holds `SEG_INSTR` instructions, followed by one 8-byte word that points to the next segment. When every slot of a segment has been fetched and another instruction is waiting, the block reads that pointer word and continues fetching at the address it returns. The block also counts the instructions that are in flight. A start-address write reconfigures the queue, and it takes effect only when the queue is quiescent. A small set of sticky status flags is cleared by writing ones. One of those flags records a doorbell overflow.

Top module: `instq_fetcher`

## Requirements
- R1: After reset, dbCount, fetchPtr, inflight and status are all 0 and reqValid is 0.
- R2: A doorbell write adds dbWrData to the 20-bit word count. Each accepted instruction request subtracts 8. When a write and an accepted request fall in the same cycle, both take effect, and dbCount shows the words still pending.
- R3: A doorbell sum of 2^20 or more keeps only its low 20 bits and sets status bit 1, which stays set until it is cleared. Writing 2^20 minus the current count brings the count to 0.
- R4: An instruction request (reqLink=0) is raised only while qEnable is 1 and dbCount is at least 8. Its reqAddr is {fetchPtr, 6'b0}. Each accepted request adds 1 to fetchPtr, which counts in 64-byte units.
- R5: After SEG_INSTR instructions of a segment are accepted, the next fetch is a pointer read (reqLink=1) at {fetchPtr, 6'b0}. It is issued only while enabled and with an instruction waiting. A linkRspValid pulse then loads linkRspPtr into fetchPtr, and a new segment begins.
- R6: While reqValid is 1 and reqReady is 0, on the next cycle reqValid stays 1 and reqAddr and reqLink are unchanged.
- R7: inflight rises by 1 for each accepted instruction request and falls by 1 on each doneStrobe. When both happen in one cycle it is unchanged. A doneStrobe at 0 leaves it at 0.
- R8: A saddrWrEn write loads saddrWrData into fetchPtr and restarts the segment. It takes effect only when qEnable is 0, inflight is 0 and no request is pending. Otherwise fetchPtr is unchanged.
- R9: Status bits 6..0 are set by statusSet pulses and cleared by ones in statusClr. When a bit is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qEnable | input | 1 | Queue enable, gates fetching |
| dbWrEn | input | 1 | Doorbell write strobe |
| dbWrData | input | 20 | Words to add to the doorbell count |
| dbCount | output | 20 | Words still pending |
| saddrWrEn | input | 1 | Start-address write strobe |
| saddrWrData | input | 43 | Start address bits 48:6 |
| fetchPtr | output | 43 | Next fetch address bits 48:6 |
| reqValid | output | 1 | Fetch request valid |
| reqReady | input | 1 | Fetch request accepted |
| reqAddr | output | 49 | Fetch byte address |
| reqLink | output | 1 | 1 for a next-segment pointer read, 0 for an instruction |
| linkRspValid | input | 1 | Next-segment pointer returned |
| linkRspPtr | input | 43 | Returned segment base, bits 48:6 |
| doneStrobe | input | 1 | One in-flight instruction finished |
| inflight | output | 8 | Instructions in flight |
| statusSet | input | 7 | Status set pulses (bit 1 is also set on overflow) |
| statusClr | input | 7 | Write-one-to-clear mask |
| status | output | 7 | Sticky status flags |

## Verification
Two things can land on the word count in the same cycle: a doorbell write, and the 8-word deduction of an accepted fetch. To provoke this, the bench holds the fetch handshake always ready and rings the doorbell 8 words at a time on consecutive cycles. Fetches therefore start and are accepted while later writes are still arriving. The scoreboard checks each fetch address in order, including the pointer read at the segment boundary. The count must settle at exactly zero, and no extra request may appear. A second collision is also provoked: a status bit is set and cleared in the same cycle, and the bench expects the bit to read back as set.

// File: rtl/instq_pkg.sv
`timescale 1ns/1ps
package instq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_LINK,
    ST_WAIT
  } fetchState_e;

  typedef struct packed {
    logic advance;   // instruction request accepted this cycle
    logic linkLoad;  // next-segment pointer arrives this cycle
    logic idle;      // no request pending
  } dpStrobe_t;
endpackage

// File: rtl/instq_ctrl.sv
`timescale 1ns/1ps
module instq_ctrl
  import instq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      qEnable,
  input  logic      instrReady,
  input  logic      segDone,
  input  logic      inflightFull,
  input  logic      reqReady,
  input  logic      linkRspValid,
  output logic      reqValid,
  output logic      reqLink,
  output dpStrobe_t strobe
);
  fetchState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (qEnable && instrReady && !inflightFull) begin
          stateNxt = segDone ? ST_LINK : ST_DATA;
        end
      end
      ST_DATA: if (reqReady) stateNxt = ST_IDLE;
      ST_LINK: if (reqReady) stateNxt = ST_WAIT;
      ST_WAIT: if (linkRspValid) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqValid        = (state == ST_DATA) || (state == ST_LINK);
  assign reqLink         = (state == ST_LINK);
  assign strobe.advance  = (state == ST_DATA) && reqReady;
  assign strobe.linkLoad = (state == ST_WAIT) && linkRspValid;
  assign strobe.idle     = (state == ST_IDLE);

  AST_FETCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(qEnable) && $past(instrReady)); // R4

  AST_LINK_AT_SEG_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqLink) |-> $past(segDone)); // R5
endmodule

// File: rtl/instq_dpath.sv
`timescale 1ns/1ps
module instq_dpath
  import instq_pkg::*;
#(
  parameter int DB_W      = 20,
  parameter int PTR_W     = 43,
  parameter int INF_W     = 8,
  parameter int ST_W      = 7,
  parameter int SEG_INSTR = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qEnable,
  input  logic             dbWrEn,
  input  logic [DB_W-1:0]  dbWrData,
  input  logic             saddrWrEn,
  input  logic [PTR_W-1:0] saddrWrData,
  input  logic [PTR_W-1:0] linkRspPtr,
  input  logic             doneStrobe,
  input  logic [ST_W-1:0]  statusSet,
  input  logic [ST_W-1:0]  statusClr,
  input  dpStrobe_t        strobe,
  output logic [DB_W-1:0]  dbCount,
  output logic [PTR_W-1:0] fetchPtr,
  output logic [INF_W-1:0] inflight,
  output logic [ST_W-1:0]  status,
  output logic             instrReady,
  output logic             segDone,
  output logic             inflightFull
);
  localparam int SLOT_W    = $clog2(SEG_INSTR + 1);
  localparam int WORDS_PER = 8;
  localparam int OVF_BIT   = 1;

  logic [SLOT_W-1:0] slot;
  logic [DB_W:0]     dbSum;
  logic              dbOvf;
  logic              cfgOk;
  logic              doneEff;

  // Deduction cannot borrow: a fetch is only pending while count >= 8
  always_comb begin
    dbSum = {1'b0, dbCount}
          - (strobe.advance ? (DB_W+1)'(WORDS_PER) : '0)
          + (dbWrEn ? {1'b0, dbWrData} : '0);
  end
  assign dbOvf = dbSum[DB_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dbCount <= '0;
    else       dbCount <= dbSum[DB_W-1:0];
  end

  assign cfgOk = saddrWrEn && !qEnable && (inflight == '0) && strobe.idle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPtr <= '0;
      slot     <= '0;
    end else if (cfgOk) begin
      fetchPtr <= saddrWrData;
      slot     <= '0;
    end else if (strobe.linkLoad) begin
      fetchPtr <= linkRspPtr;
      slot     <= '0;
    end else if (strobe.advance) begin
      fetchPtr <= fetchPtr + PTR_W'(1);
      slot     <= slot + SLOT_W'(1);
    end
  end

  assign doneEff = doneStrobe && (inflight != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inflight <= '0;
    else begin
      case ({strobe.advance, doneEff})
        2'b10:   inflight <= inflight + INF_W'(1);
        2'b01:   inflight <= inflight - INF_W'(1);
        default: inflight <= inflight;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~statusClr) | statusSet
                         | (ST_W'(dbOvf) << OVF_BIT);
  end

  assign instrReady   = dbCount >= DB_W'(WORDS_PER);
  assign segDone      = slot == SLOT_W'(SEG_INSTR);
  assign inflightFull = &inflight;

  AST_NO_SEG_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (slot < SLOT_W'(SEG_INSTR))); // R5

  AST_INFLIGHT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (inflight != $past(inflight)) |->
      (inflight == $past(inflight) + INF_W'(1)) ||
      (inflight == $past(inflight) - INF_W'(1))); // R7

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    status[OVF_BIT] && !statusClr[OVF_BIT] |=> status[OVF_BIT]); // R3
endmodule

// File: rtl/instq_fetcher.sv
`timescale 1ns/1ps
module instq_fetcher
  import instq_pkg::*;
#(
  parameter int DB_W      = 20,
  parameter int PTR_W     = 43,
  parameter int INF_W     = 8,
  parameter int ST_W      = 7,
  parameter int SEG_INSTR = 4,
  localparam int ADDR_W   = PTR_W + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qEnable,
  input  logic              dbWrEn,
  input  logic [DB_W-1:0]   dbWrData,
  output logic [DB_W-1:0]   dbCount,
  input  logic              saddrWrEn,
  input  logic [PTR_W-1:0]  saddrWrData,
  output logic [PTR_W-1:0]  fetchPtr,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqLink,
  input  logic              linkRspValid,
  input  logic [PTR_W-1:0]  linkRspPtr,
  input  logic              doneStrobe,
  output logic [INF_W-1:0]  inflight,
  input  logic [ST_W-1:0]   statusSet,
  input  logic [ST_W-1:0]   statusClr,
  output logic [ST_W-1:0]   status
);
  dpStrobe_t strobe;
  logic      instrReady;
  logic      segDone;
  logic      inflightFull;

  instq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .qEnable      (qEnable),
    .instrReady   (instrReady),
    .segDone      (segDone),
    .inflightFull (inflightFull),
    .reqReady     (reqReady),
    .linkRspValid (linkRspValid),
    .reqValid     (reqValid),
    .reqLink      (reqLink),
    .strobe       (strobe)
  );

  instq_dpath #(
    .DB_W(DB_W), .PTR_W(PTR_W), .INF_W(INF_W), .ST_W(ST_W), .SEG_INSTR(SEG_INSTR)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .qEnable      (qEnable),
    .dbWrEn       (dbWrEn),
    .dbWrData     (dbWrData),
    .saddrWrEn    (saddrWrEn),
    .saddrWrData  (saddrWrData),
    .linkRspPtr   (linkRspPtr),
    .doneStrobe   (doneStrobe),
    .statusSet    (statusSet),
    .statusClr    (statusClr),
    .strobe       (strobe),
    .dbCount      (dbCount),
    .fetchPtr     (fetchPtr),
    .inflight     (inflight),
    .status       (status),
    .instrReady   (instrReady),
    .segDone      (segDone),
    .inflightFull (inflightFull)
  );

  assign reqAddr = {fetchPtr, 6'b0};

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLink)); // R6
endmodule

// File: tb/test_instq_fetcher.sv
`timescale 1ns/1ps
module test_instq_fetcher;
  logic        clk = 1'b0;
  logic        rstN;
  logic        qEnable, dbWrEn, saddrWrEn, reqReady, linkRspValid, doneStrobe;
  logic [19:0] dbWrData, dbCount;
  logic [42:0] saddrWrData, fetchPtr, linkRspPtr;
  logic        reqValid, reqLink;
  logic [48:0] reqAddr;
  logic [7:0]  inflight;
  logic [6:0]  statusSet, statusClr, status;

  always #2.5 clk = ~clk;

  instq_fetcher i_instq_fetcher (
    .clk(clk), .rstN(rstN), .qEnable(qEnable), .dbWrEn(dbWrEn), .dbWrData(dbWrData),
    .dbCount(dbCount), .saddrWrEn(saddrWrEn), .saddrWrData(saddrWrData),
    .fetchPtr(fetchPtr), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLink(reqLink), .linkRspValid(linkRspValid), .linkRspPtr(linkRspPtr),
    .doneStrobe(doneStrobe), .inflight(inflight), .statusSet(statusSet),
    .statusClr(statusClr), .status(status)
  );

  int nChecks = 0;
  int nFail   = 0;
  logic [43:0] expQ[$];      // {isLink, ptr}
  logic [42:0] linkTgtQ[$];
  bit  readyAll = 1'b0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  // driver-side scoreboard pushes
  task automatic pushFetch(logic [42:0] p);
    expQ.push_back({1'b0, p});
  endtask

  task automatic pushLink(logic [42:0] p, logic [42:0] tgt);
    expQ.push_back({1'b1, p});
    linkTgtQ.push_back(tgt);
  endtask

  task automatic ring(logic [19:0] v);
    @(negedge clk); dbWrEn = 1'b1; dbWrData = v;
    @(negedge clk); dbWrEn = 1'b0;
  endtask

  task automatic setAddr(logic [42:0] v);
    @(negedge clk); saddrWrEn = 1'b1; saddrWrData = v;
    @(negedge clk); saddrWrEn = 1'b0;
  endtask

  task automatic done(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); doneStrobe = 1'b1;
    end
    @(negedge clk); doneStrobe = 1'b0;
  endtask

  task automatic stat(logic [6:0] s, logic [6:0] c);
    @(negedge clk); statusSet = s; statusClr = c;
    @(negedge clk); statusSet = '0; statusClr = '0;
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() != 0 && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (8) @(negedge clk);
    check("R5 scoreboard empty", 64'(expQ.size()), 64'd0);
  endtask

  // monitor: drives ready and link responses, compares accepted requests
  initial begin : monitor
    int tick = 0;
    int linkDelay = 0;
    logic [42:0] linkTgt = '0;
    bit holdPend = 1'b0;
    logic [50:0] holdVal = '0;
    logic [43:0] e;
    reqReady = 1'b0; linkRspValid = 1'b0; linkRspPtr = '0;
    forever begin
      @(negedge clk);
      linkRspValid = 1'b0;
      if (linkDelay != 0) begin
        linkDelay--;
        if (linkDelay == 0) begin
          linkRspValid = 1'b1;
          linkRspPtr   = linkTgt;
        end
      end
      if (holdPend) begin
        check("R6 held request", 64'({reqValid, reqLink, reqAddr}), 64'(holdVal));
        holdPend = 1'b0;
      end
      tick++;
      reqReady = readyAll ? 1'b1 : ((tick % 3) != 0);
      if (reqValid === 1'b1 && reqReady) begin
        if (expQ.size() == 0) begin
          check("R4 unexpected request", 64'({1'b1, reqLink, reqAddr}), 64'd0);
        end else begin
          e = expQ.pop_front();
          check(e[43] ? "R5 link fetch" : "R4 instr fetch",
                64'({reqLink, reqAddr}), 64'({e[43], e[42:0], 6'b0}));
          if (e[43] && linkTgtQ.size() != 0) begin
            linkTgt   = linkTgtQ.pop_front();
            linkDelay = 2;
          end
        end
      end else if (reqValid === 1'b1) begin
        holdPend = 1'b1;
        holdVal  = {1'b1, reqLink, reqAddr};
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stimulus
    rstN = 1'b0; qEnable = 1'b0; dbWrEn = 1'b0; dbWrData = '0;
    saddrWrEn = 1'b0; saddrWrData = '0; doneStrobe = 1'b0;
    statusSet = '0; statusClr = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 dbCount",  64'(dbCount),  64'd0);
    check("R1 fetchPtr", 64'(fetchPtr), 64'd0);
    check("R1 inflight", 64'(inflight), 64'd0);
    check("R1 status",   64'(status),   64'd0);
    check("R1 reqValid", 64'(reqValid), 64'd0);

    // R8 load while quiescent
    setAddr(43'h100);
    check("R8 load quiescent", 64'(fetchPtr), 64'h100);

    // R4 R5 first segment plus link
    pushFetch(43'h100); pushFetch(43'h101); pushFetch(43'h102); pushFetch(43'h103);
    pushLink(43'h104, 43'h200); pushFetch(43'h200);
    qEnable = 1'b1;
    ring(20'd40);
    drain();
    check("R2 count consumed", 64'(dbCount),  64'd0);
    check("R5 ptr after link", 64'(fetchPtr), 64'h201);
    check("R7 inflight 5",     64'(inflight), 64'd5);

    // R8 ignored while enabled, and while disabled with inflight
    setAddr(43'h300);
    check("R8 ignored enabled", 64'(fetchPtr), 64'h201);
    qEnable = 1'b0;
    setAddr(43'h300);
    check("R8 ignored inflight", 64'(fetchPtr), 64'h201);

    // R7 completions
    done(3);
    check("R7 inflight after 3 done", 64'(inflight), 64'd2);
    done(3);
    check("R7 done at zero", 64'(inflight), 64'd0);

    // R4 disabled gating
    ring(20'd16);
    repeat (20) @(negedge clk);
    check("R4 no fetch disabled count", 64'(dbCount),  64'd16);
    check("R4 no fetch disabled valid", 64'(reqValid), 64'd0);
    pushFetch(43'h201); pushFetch(43'h202);
    qEnable = 1'b1;
    drain();
    check("R2 count after enable", 64'(dbCount),  64'd0);
    check("R7 inflight 2",         64'(inflight), 64'd2);

    // R2 doorbell writes colliding with fetch deduction
    readyAll = 1'b1;
    pushFetch(43'h203); pushLink(43'h204, 43'h400);
    pushFetch(43'h400); pushFetch(43'h401); pushFetch(43'h402); pushFetch(43'h403);
    @(negedge clk); dbWrEn = 1'b1; dbWrData = 20'd8;
    repeat (5) @(negedge clk);
    dbWrEn = 1'b0;
    drain();
    check("R2 collide count", 64'(dbCount),  64'd0);
    check("R7 inflight 7",    64'(inflight), 64'd7);
    check("R4 ptr 404",       64'(fetchPtr), 64'h404);
    readyAll = 1'b0;

    // R3 overflow and recipe
    qEnable = 1'b0;
    ring(20'hFFFF8);
    check("R3 near full",   64'(dbCount),   64'hFFFF8);
    check("R3 no ovf yet",  64'(status[1]), 64'd0);
    ring(20'd16);
    check("R3 wrapped",     64'(dbCount),   64'd8);
    check("R3 ovf set",     64'(status[1]), 64'd1);
    ring(20'hFFFF8);
    check("R3 recipe zero", 64'(dbCount),   64'd0);
    stat(7'h00, 7'h02);
    check("R3 ovf cleared", 64'(status),    64'd0);

    // R9 status
    stat(7'h11, 7'h00);
    check("R9 set",          64'(status), 64'h11);
    stat(7'h00, 7'h01);
    check("R9 clear one",    64'(status), 64'h10);
    stat(7'h40, 7'h40);
    check("R9 set wins",     64'(status), 64'h50);
    stat(7'h00, 7'h7F);
    check("R9 clear all",    64'(status), 64'h00);

    // R8 reconfigure after quiescence restarts segment
    done(7);
    check("R7 drained", 64'(inflight), 64'd0);
    setAddr(43'h500);
    check("R8 reload", 64'(fetchPtr), 64'h500);
    pushFetch(43'h500); pushFetch(43'h501); pushFetch(43'h502); pushFetch(43'h503);
    pushLink(43'h504, 43'h600); pushFetch(43'h600);
    qEnable = 1'b1;
    ring(20'd40);
    drain();
    check("R8 segment restarted", 64'(fetchPtr), 64'h601);
    check("R2 final count",       64'(dbCount),  64'd0);

    summary();
  end
endmodule